// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block serialises one data word per frame onto a single output line, which rests high when nothing is being sent. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. A mode input picks the word width. When parity is switched on, the parity bit goes out in the last data-bit slot in place of that data bit, so a frame is always as long as the word width makes it.

Besides data, the block can send two kinds of special frame when asked by a request strobe. An idle frame is one frame time of unbroken high. A break is one frame time of low, and it repeats while the request is still held. After the last break frame the line goes high for one extra bit time. Bit timing comes from the block's own tick counter, which reloads from a 16-bit divisor input. The host offers words through a valid/ready handshake and watches the busy and complete outputs.

Top module: `async_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `done` is 0. `txd` is 1 whenever `busy` is 0.
- R2: A data frame on `txd` is one 0 start bit, then W data bits with `tx_data[0]` first, then one 1 stop bit. W is 8 when `wide_mode`=0 and 9 when `wide_mode`=1, so the frame is W+2 bit times long.
- R3: Each bit lasts max(`bit_div`,1) clock cycles. The first bit appears on `txd` in the cycle after the accepting clock edge, and `busy` stays high for exactly (W+2)·max(`bit_div`,1) cycles.
- R4: With `par_en`=1, data bit position W-1 carries a parity bit instead of `tx_data[W-1]`. The parity bit is the XOR of `tx_data[W-2:0]` and `par_odd`, so `par_odd`=0 gives even parity and `par_odd`=1 gives odd parity.
- R5: An accepted `idle_req` holds `txd` at 1 for W+2 bit times, with no start bit.
- R6: An accepted `break_req` drives `txd` to 0 for W+2 bit times. If `break_req` is still 1 at the end of a break frame, another break frame follows straight away.
- R7: After the last break frame, `txd` is 1 for one extra bit time before the frame ends. A following start bit can come no earlier than one cycle after that.
- R8: `tx_ready` = !`busy` & !`break_req` & !`idle_req`. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both 1.
- R9: Requests and data offered while `busy` is 1 have no effect on the frame in flight or on the frames that follow.
- R10: When requests arrive together, `break_req` wins over `idle_req`, and `idle_req` wins over a data word.
- R11: `done` is a one-cycle pulse in the first cycle after a stop bit, an idle frame or a break's extra high bit, which is also the cycle where `busy` falls. `busy` never falls without `done`.
- R12: `wide_mode`, `par_en`, `par_odd` and `tx_data` are captured when a frame is accepted. Changing them mid-frame does not change the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_div | input | 16 | Cycles per bit (0 behaves as 1) |
| wide_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Parity bit replaces the last data bit |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| tx_data | input | 9 | Word to send (bit 8 used only in 9-bit mode) |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Word will be taken on this edge |
| idle_req | input | 1 | Request an idle frame |
| break_req | input | 1 | Request a break; hold it to repeat |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a break that runs for more than one frame and is then followed straight away by a data word. The request has to stay high across the exact tick that ends the first break frame and then drop before the second one ends. The word has to be waiting the whole time with valid held high, so the bench can see that the extra high bit comes between the break and the new start bit. The bench holds the break request for a fixed number of cycles chosen to land inside the second frame. It then measures how long the line stays low and how long the following high stretch lasts. A second case changes the mode, parity settings and data, and pulses both requests, while a data frame is in flight. This checks that none of these change the frame being sent.

// File: rtl/aft_pkg.sv
package aft_pkg;

    localparam int AFT_DATA_W    = 9;
    localparam int AFT_FRAME_MAX = AFT_DATA_W + 2;
    localparam int AFT_LEN_W     = $clog2(AFT_FRAME_MAX + 1);

    typedef enum logic [1:0] {
        FK_DATA,
        FK_IDLE,
        FK_BREAK
    } frame_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_MARK
    } seq_state_e;

    typedef struct packed {
        logic [AFT_FRAME_MAX-1:0] bits;
        logic [AFT_LEN_W-1:0]     len;
        frame_kind_e              kind;
    } frame_s;

    // number of data bits in a frame for the selected mode
    function automatic logic [AFT_LEN_W-1:0] word_bits(input logic wide);
        return wide ? AFT_LEN_W'(AFT_DATA_W) : AFT_LEN_W'(AFT_DATA_W - 1);
    endfunction

    // parity over the lowest n bits of d, seeded with the odd selector
    function automatic logic parity_of(input logic [AFT_DATA_W-1:0] d,
                                       input logic [AFT_LEN_W-1:0]  n,
                                       input logic                  odd);
        logic p;
        p = odd;
        for (int i = 0; i < AFT_DATA_W; i++) begin
            if (i < int'(n)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/aft_baud.sv
module aft_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             load,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] reload;

    assign reload = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    assign tick   = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (run) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - DIV_W'(1);
        end
    end
endmodule

// File: rtl/aft_framer.sv
module aft_framer
    import aft_pkg::*;
(
    input  logic                  wide,
    input  logic                  par_en,
    input  logic                  par_odd,
    input  logic [AFT_DATA_W-1:0] data,
    input  frame_kind_e           kind,
    output frame_s                frame
);
    logic [AFT_LEN_W-1:0] n;

    always_comb begin
        n          = word_bits(wide);
        frame.len  = n + AFT_LEN_W'(2);
        frame.kind = kind;
        frame.bits = '1;
        case (kind)
            FK_BREAK: frame.bits = '0;
            FK_IDLE:  frame.bits = '1;
            default: begin
                frame.bits[0] = 1'b0;
                for (int i = 0; i < AFT_DATA_W; i++) begin
                    if (i < int'(n)) frame.bits[i+1] = data[i];
                end
                if (par_en) frame.bits[n] = parity_of(data, n - AFT_LEN_W'(1), par_odd);
            end
        endcase
    end
endmodule

// File: rtl/aft_seq.sv
module aft_seq
    import aft_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   start,
    input  frame_s nxt,
    input  logic   break_req,
    output logic   txd,
    output logic   busy,
    output logic   done
);
    seq_state_e               state;
    logic [AFT_FRAME_MAX-1:0] sh;
    logic [AFT_LEN_W-1:0]     left;
    logic [AFT_LEN_W-1:0]     len_q;
    frame_kind_e              kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            sh     <= '1;
            left   <= '0;
            len_q  <= '0;
            kind_q <= FK_DATA;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        sh     <= nxt.bits;
                        left   <= nxt.len;
                        len_q  <= nxt.len;
                        kind_q <= nxt.kind;
                        state  <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (tick) begin
                        if (left == AFT_LEN_W'(1)) begin
                            if (kind_q == FK_BREAK) begin
                                if (break_req) begin
                                    sh   <= '0;
                                    left <= len_q;
                                end else begin
                                    state <= SQ_MARK;
                                end
                            end else begin
                                state <= SQ_IDLE;
                                done  <= 1'b1;
                            end
                        end else begin
                            sh   <= {1'b1, sh[AFT_FRAME_MAX-1:1]};
                            left <= left - AFT_LEN_W'(1);
                        end
                    end
                end
                SQ_MARK: begin
                    if (tick) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign txd  = (state == SQ_SEND) ? sh[0] : 1'b1;
    assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import aft_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DIV_W-1:0]      bit_div,
    input  logic                  wide_mode,
    input  logic                  par_en,
    input  logic                  par_odd,
    input  logic [AFT_DATA_W-1:0] tx_data,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    input  logic                  idle_req,
    input  logic                  break_req,
    output logic                  txd,
    output logic                  busy,
    output logic                  done
);
    frame_kind_e kind;
    frame_s      nxt;
    logic        go;
    logic        tick;

    always_comb begin
        if (break_req)     kind = FK_BREAK;
        else if (idle_req) kind = FK_IDLE;
        else               kind = FK_DATA;
    end

    assign go       = !busy && (break_req || idle_req || tx_valid);
    assign tx_ready = !busy && !break_req && !idle_req;

    aft_framer u_framer (
        .wide    (wide_mode),
        .par_en  (par_en),
        .par_odd (par_odd),
        .data    (tx_data),
        .kind    (kind),
        .frame   (nxt)
    );

    aft_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor (bit_div),
        .load    (go),
        .run     (busy),
        .tick    (tick)
    );

    aft_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (go),
        .nxt       (nxt),
        .break_req (break_req),
        .txd       (txd),
        .busy      (busy),
        .done      (done)
    );
endmodule

// File: rtl/aft_checker.sv
module aft_checker (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic tx_ready,
    input logic idle_req,
    input logic break_req,
    input logic txd,
    input logic busy,
    input logic done
);
    assert_idle_line_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (!txd && busy));

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !break_req && idle_req) |=> (txd && busy));

    // R10: break wins, so the line drops even when other requests are present
    assert_break_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && break_req) |=> (!txd && busy));

    assert_done_end_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_fall_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind async_frame_tx aft_checker u_aft_checker (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .idle_req  (idle_req),
    .break_req (break_req),
    .txd       (txd),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_async_frame_tx.sv
`timescale 1ns/1ps
module tb_async_frame_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bit_div = 16'd3;
    logic        wide_mode = 1'b0;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic [8:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        idle_req = 1'b0;
    logic        break_req = 1'b0;
    logic        txd;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    async_frame_tx dut (
        .clk(clk), .rst(rst), .bit_div(bit_div), .wide_mode(wide_mode),
        .par_en(par_en), .par_odd(par_odd), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .idle_req(idle_req),
        .break_req(break_req), .txd(txd), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit    q[$];
    int    cyc;
    bit    m_busy, m_done, brk;
    int    nbits;
    string ttag = "R1";

    function automatic int dlen();
        return (bit_div == 0) ? 1 : int'(bit_div);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); cyc = 0; m_busy = 0; m_done = 0; brk = 0; ttag = "R1";
        end else begin
            m_done = 0;
            if (m_busy) begin
                cyc++;
                if (cyc >= dlen()) begin
                    cyc = 0;
                    void'(q.pop_front());
                    if (q.size() == 0) begin
                        if (brk && break_req) begin
                            for (int i = 0; i < nbits + 2; i++) q.push_back(1'b0);
                        end else if (brk) begin
                            q.push_back(1'b1); brk = 0; ttag = "R7";
                        end else begin
                            m_busy = 0; m_done = 1; ttag = "R1";
                        end
                    end
                end
            end else if (break_req || idle_req || tx_valid) begin
                nbits = wide_mode ? 9 : 8;
                m_busy = 1; cyc = 0;
                if (break_req) begin
                    brk = 1; ttag = "R6";
                    for (int i = 0; i < nbits + 2; i++) q.push_back(1'b0);
                end else if (idle_req) begin
                    ttag = "R5";
                    for (int i = 0; i < nbits + 2; i++) q.push_back(1'b1);
                end else begin
                    bit p;
                    p = par_odd;
                    for (int j = 0; j < nbits - 1; j++) p ^= tx_data[j];
                    ttag = par_en ? "R4" : "R2";
                    q.push_back(1'b0);
                    for (int i = 0; i < nbits; i++)
                        q.push_back((par_en && i == nbits - 1) ? p : tx_data[i]);
                    q.push_back(1'b1);
                end
            end
        end
    end

    // per-cycle comparison and run-length monitors
    int lo = 0, hi = 0, brun = 0, last_lo = 0, last_hi = 0, last_brun = 0, done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            bit m_txd;
            m_txd = m_busy ? q[0] : 1'b1;
            chk(txd === m_txd, ttag, txd, m_txd);
            chk(busy === m_busy, "R11 busy", busy, m_busy);
            chk(done === m_done, "R11 done", done, m_done);
            chk(tx_ready === (!m_busy && !break_req && !idle_req), "R8 ready",
                tx_ready, (!m_busy && !break_req && !idle_req));
            if (!txd) begin lo++; if (hi != 0) last_hi = hi; hi = 0; end
            else      begin hi++; if (lo != 0) last_lo = lo; lo = 0; end
            if (busy) brun++;
            else begin if (brun != 0) last_brun = brun; brun = 0; end
            if (done) done_cnt++;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_quiet();
        while (busy) step();
        step();
    endtask

    task automatic send(input logic [8:0] d, input bit w, input bit pe, input bit po);
        tx_data = d; wide_mode = w; par_en = pe; par_odd = po; tx_valid = 1'b1;
        while (!tx_ready) step();
        step();
        tx_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1: reset state
        chk(txd === 1'b1, "R1 txd", txd, 1);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);

        // R2/R3: plain 8-bit frame, 3 cycles per bit
        bit_div = 16'd3;
        send(9'h0A5, 0, 0, 0);
        wait_quiet();
        chk(last_brun == 30, "R3 busy length", last_brun, 30);

        // R2: 9-bit frame, 2 cycles per bit
        bit_div = 16'd2;
        send(9'h1C3, 1, 0, 0);
        wait_quiet();
        chk(last_brun == 22, "R3 9-bit busy length", last_brun, 22);

        // R4: parity variants
        send(9'h0B7, 0, 1, 0); wait_quiet();
        send(9'h0B7, 0, 1, 1); wait_quiet();
        send(9'h155, 1, 1, 1); wait_quiet();

        // R3: divisor 0 acts as 1
        bit_div = 16'd0;
        send(9'h0F0, 1, 1, 0);
        wait_quiet();
        chk(last_brun == 11, "R3 divisor zero", last_brun, 11);

        // R5: idle frame
        bit_div = 16'd2; wide_mode = 1'b0;
        idle_req = 1'b1; step(); idle_req = 1'b0;
        wait_quiet();
        chk(last_brun == 20, "R5 idle length", last_brun, 20);

        // R6/R7: single break
        break_req = 1'b1; step(); break_req = 1'b0;
        wait_quiet();
        chk(last_lo == 20, "R6 single break low", last_lo, 20);
        chk(last_brun == 22, "R7 break plus mark", last_brun, 22);

        // R6/R7: held break for two frames, word waiting behind it
        break_req = 1'b1; step(25);
        break_req = 1'b0;
        tx_data = 9'h03C; wide_mode = 1'b0; par_en = 1'b0; tx_valid = 1'b1;
        while (!txd) step();
        step();
        chk(last_lo == 40, "R6 repeated break low", last_lo, 40);
        while (!tx_ready) step();
        step();
        tx_valid = 1'b0;
        step();
        chk(last_hi == 3, "R7 extra mark before start", last_hi, 3);
        wait_quiet();

        // R10: all requests in one cycle, break wins
        break_req = 1'b1; idle_req = 1'b1; tx_valid = 1'b1; tx_data = 9'h000;
        step();
        break_req = 1'b0; idle_req = 1'b0; tx_valid = 1'b0;
        wait_quiet();
        chk(last_lo == 20, "R10 break won", last_lo, 20);
        step(3);
        chk(busy === 1'b0, "R10 losers dropped", busy, 0);

        // R9/R12: inputs and requests changed mid-frame
        send(9'h0C3, 0, 0, 0);
        step(3);
        wide_mode = 1'b1; par_en = 1'b1; par_odd = 1'b1; tx_data = 9'h1FF;
        idle_req = 1'b1; step(); idle_req = 1'b0;
        step(2);
        break_req = 1'b1; step(); break_req = 1'b0;
        wait_quiet();
        chk(last_brun == 20, "R12 captured settings", last_brun, 20);
        step(4);
        chk(busy === 1'b0, "R9 busy requests ignored", busy, 0);

        chk(done_cnt == 12, "R11 done pulses", done_cnt, 12);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule